// File: doc/BRIEF.md
# Packet dependency pattern recorder

This block watches the network traffic of a single processing element and condenses it into a small table of injection rules. Each cycle it may see at most one packet arrival, tagged with the node that sent it, and at most one outgoing send, tagged with a destination node and a flit count. Arrivals are collected into a 16-bit vector, one bit per node of a 4x4 mesh. The vector is gathered over a fixed capture window of `INTERVAL` cycles.

When a send happens, the block forms a rule. The rule holds the arrival vector as it stands at that moment, together with the destination and flit count. If an identical rule is already stored, the new one is folded into it and a small saturating hit counter on that rule is raised. If not, the rule takes the next free slot. Once all slots are taken, new unique rules are discarded and a sticky overflow flag is raised.

A synchronous read port gives access to any slot of the table, so the rules can later drive a traffic generator. Arrivals sharpen the rule of the send that follows them, and the window clear keeps stale arrivals from leaking into later rules.

Top module: `rule_recorder`

## Requirements
- R1: An arrival with `rx_valid` high and source `rx_src` = s sets bit s of the arrival vector. Bits accumulate across cycles until the vector is cleared.
- R2: A send with `tx_valid` high whose key matches no stored rule is written into the lowest unused slot. Slots fill in the order sends arrive, starting at index 0. The key is {arrival vector, `tx_dst`, `tx_flits`}. The new rule has its used bit at 1 and its hit count at 0.
- R3: A send whose key equals that of a stored rule creates no new slot. It raises that rule's 2-bit hit count by one, and the count holds at 3 once it gets there.
- R4: The arrival vector is all zeros in the cycle after any send.
- R5: A window counter starts at reset and ends a window every `INTERVAL` cycles; the first window ends on the `INTERVAL`-th clock edge after reset is released. An arrival in the last cycle of a window still counts toward a send in that same cycle. After that edge the vector is all zeros.
- R6: When an arrival and a send occur in the same cycle, the arrival's bit is part of the vector stored with that send.
- R7: When all `DEPTH` slots are used, a send with a new key is dropped and `overflow` goes high and stays high until reset. A send matching a stored rule still merges into it.
- R8: `rd_en` high with index `rd_idx` makes `rd_valid` high on the next cycle, showing that slot's used bit, hit count, vector, destination and flit count as they were before that edge. An unused slot reads back as all zeros. `rd_valid` is low in the cycle after `rd_en` is low.
- R9: After reset every slot is unused and reads back as zeros, `overflow` is low and `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A packet arrived this cycle |
| rx_src | input | 4 | Node that sent the arriving packet |
| tx_valid | input | 1 | The element sends a packet this cycle |
| tx_dst | input | 4 | Destination node of the send |
| tx_flits | input | 8 | Flit count of the send |
| rd_en | input | 1 | Table read request |
| rd_idx | input | $clog2(DEPTH) | Slot to read |
| rd_valid | output | 1 | Read data is present this cycle |
| rd_used | output | 1 | Slot holds a rule |
| rd_hits | output | 2 | Saturating merge count of the slot |
| rd_deps | output | 16 | Arrival vector of the slot |
| rd_dst | output | 4 | Destination of the slot |
| rd_flits | output | 8 | Flit count of the slot |
| overflow | output | 1 | Sticky: a unique rule was dropped on a full table |

## Verification
The properties assume that every input is a known value from the first cycle after reset. They also assume that `rd_idx` stays below `DEPTH`, so a read never addresses a missing slot, and that a send and a read are never requested for the same slot in the same cycle when a new value is expected back. The stimulus meets these assumptions. It holds every input at zero during reset and changes inputs only on falling edges. It issues reads only in cycles with no send. It counts clock edges from reset release, so that it can place arrivals and sends exactly on the last cycle of a capture window.

// File: rtl/rulerec_pkg.sv
`timescale 1ns/1ps
package rulerec_pkg;
    localparam int NODE_CNT = 16;
    localparam int NODE_W   = $clog2(NODE_CNT);
    localparam int FLIT_W   = 8;
    localparam int HIT_W    = 2;

    typedef logic [NODE_CNT-1:0] depvec_t;

    typedef struct packed {
        depvec_t             deps;
        logic [NODE_W-1:0]   dst;
        logic [FLIT_W-1:0]   flits;
    } rule_key_t;

    typedef struct packed {
        logic               valid;
        logic [HIT_W-1:0]   hits;
        rule_key_t          key;
    } rule_t;

    // saturating increment of a merge counter
    function automatic logic [HIT_W-1:0] hit_bump(input logic [HIT_W-1:0] h);
        return (&h) ? h : h + 1'b1;
    endfunction

    // one-hot bit for a source node, zero when no arrival
    function automatic depvec_t src_bit(input logic v, input logic [NODE_W-1:0] s);
        depvec_t r;
        r = '0;
        if (v) r[s] = 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/dep_window.sv
`timescale 1ns/1ps
module dep_window
    import rulerec_pkg::*;
#(
    parameter int INTERVAL = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [NODE_W-1:0] rx_src,
    input  logic              tx_valid,
    output depvec_t           cur_deps,
    output depvec_t           held_deps
);
    localparam int CNT_W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

    logic [CNT_W-1:0] win_cnt;
    logic             win_end;

    assign win_end  = (win_cnt == CNT_W'(INTERVAL - 1));
    // same-cycle arrival is visible to a same-cycle send
    assign cur_deps = held_deps | src_bit(rx_valid, rx_src);

    always_ff @(posedge clk) begin
        if (rst) begin
            win_cnt   <= '0;
            held_deps <= '0;
        end else begin
            win_cnt   <= win_end ? '0 : win_cnt + 1'b1;
            held_deps <= (tx_valid || win_end) ? '0 : cur_deps;
        end
    end
endmodule

// File: rtl/rule_match.sv
`timescale 1ns/1ps
module rule_match
    import rulerec_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  rule_t [DEPTH-1:0] entries,
    input  rule_key_t         key,
    output logic              hit,
    output logic [IDX_W-1:0]  hit_idx
);
    logic [DEPTH-1:0] match;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = entries[g].valid && (entries[g].key == key);
    end

    always_comb begin
        hit     = |match;
        hit_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match[i]) hit_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/rule_table.sv
`timescale 1ns/1ps
module rule_table
    import rulerec_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int FILL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  rule_key_t         key,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output rule_t             rd_rule,
    output logic              overflow,
    output logic [FILL_W-1:0] fill
);
    rule_t [DEPTH-1:0] entries;
    logic              hit;
    logic [IDX_W-1:0]  hit_idx;
    logic              has_room;

    rule_match #(.DEPTH(DEPTH)) u_match (
        .entries (entries),
        .key     (key),
        .hit     (hit),
        .hit_idx (hit_idx)
    );

    assign has_room = (fill < FILL_W'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            entries  <= '0;
            fill     <= '0;
            overflow <= 1'b0;
            rd_valid <= 1'b0;
            rd_rule  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                rd_rule <= (32'(rd_idx) < DEPTH) ? entries[rd_idx] : '0;
            end
            if (wr) begin
                if (hit) begin
                    entries[hit_idx].hits <= hit_bump(entries[hit_idx].hits);
                end else if (has_room) begin
                    entries[fill[IDX_W-1:0]] <= '{valid: 1'b1, hits: '0, key: key};
                    fill <= fill + 1'b1;
                end else begin
                    overflow <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rule_recorder.sv
`timescale 1ns/1ps
module rule_recorder
    import rulerec_pkg::*;
#(
    parameter int DEPTH    = 32,
    parameter int INTERVAL = 64,
    localparam int IDX_W   = $clog2(DEPTH),
    localparam int FILL_W  = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rx_valid,
    input  logic [NODE_W-1:0]   rx_src,
    input  logic                tx_valid,
    input  logic [NODE_W-1:0]   tx_dst,
    input  logic [FLIT_W-1:0]   tx_flits,
    input  logic                rd_en,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic                rd_valid,
    output logic                rd_used,
    output logic [HIT_W-1:0]    rd_hits,
    output logic [NODE_CNT-1:0] rd_deps,
    output logic [NODE_W-1:0]   rd_dst,
    output logic [FLIT_W-1:0]   rd_flits,
    output logic                overflow
);
    depvec_t           cur_deps;
    depvec_t           held_deps;
    rule_key_t         new_key;
    rule_t             rd_rule;
    logic [FILL_W-1:0] fill;

    dep_window #(.INTERVAL(INTERVAL)) u_window (
        .clk       (clk),
        .rst       (rst),
        .rx_valid  (rx_valid),
        .rx_src    (rx_src),
        .tx_valid  (tx_valid),
        .cur_deps  (cur_deps),
        .held_deps (held_deps)
    );

    assign new_key = '{deps: cur_deps, dst: tx_dst, flits: tx_flits};

    rule_table #(.DEPTH(DEPTH)) u_table (
        .clk      (clk),
        .rst      (rst),
        .wr       (tx_valid),
        .key      (new_key),
        .rd_en    (rd_en),
        .rd_idx   (rd_idx),
        .rd_valid (rd_valid),
        .rd_rule  (rd_rule),
        .overflow (overflow),
        .fill     (fill)
    );

    assign rd_used  = rd_rule.valid;
    assign rd_hits  = rd_rule.hits;
    assign rd_deps  = rd_rule.key.deps;
    assign rd_dst   = rd_rule.key.dst;
    assign rd_flits = rd_rule.key.flits;
endmodule

// File: rtl/rule_recorder_chk.sv
`timescale 1ns/1ps
module rule_recorder_chk
    import rulerec_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int FILL_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              tx_valid,
    input logic              rd_en,
    input logic              rd_valid,
    input logic              overflow,
    input depvec_t           held_deps,
    input logic [FILL_W-1:0] fill
);
    // R2: slot count never exceeds the table size
    a_r2_fill_bound: assert property (@(posedge clk) disable iff (rst)
        fill <= FILL_W'(DEPTH));

    // R2: slots are claimed one at a time, only on a send
    a_r2_fill_step: assert property (@(posedge clk) disable iff (rst)
        (fill != $past(fill)) |-> (fill == $past(fill) + 1'b1) && $past(tx_valid));

    // R4: vector is empty right after a send
    a_r4_clear_after_send: assert property (@(posedge clk) disable iff (rst)
        tx_valid |=> (held_deps == '0));

    // R7: overflow is sticky
    a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    // R7: overflow only with a full table
    a_r7_overflow_full: assert property (@(posedge clk) disable iff (rst)
        overflow |-> (fill == FILL_W'(DEPTH)));

    // R7: overflow rises only because of a send
    a_r7_rise_on_send: assert property (@(posedge clk) disable iff (rst)
        $rose(overflow) |-> $past(tx_valid));

    // R8: read data one cycle after a request
    a_r8_read_latency: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);

    // R8: no read data without a request
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid);
endmodule

bind rule_recorder rule_recorder_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tx_valid  (tx_valid),
    .rd_en     (rd_en),
    .rd_valid  (rd_valid),
    .overflow  (overflow),
    .held_deps (held_deps),
    .fill      (fill)
);

// File: tb/rule_recorder_test.sv
`timescale 1ns/1ps
module rule_recorder_test;
    import rulerec_pkg::*;

    localparam int DEPTH    = 32;
    localparam int INTERVAL = 16;
    localparam int IDX_W    = $clog2(DEPTH);

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                rx_valid = 1'b0;
    logic [NODE_W-1:0]   rx_src = '0;
    logic                tx_valid = 1'b0;
    logic [NODE_W-1:0]   tx_dst = '0;
    logic [FLIT_W-1:0]   tx_flits = '0;
    logic                rd_en = 1'b0;
    logic [IDX_W-1:0]    rd_idx = '0;
    logic                rd_valid;
    logic                rd_used;
    logic [HIT_W-1:0]    rd_hits;
    logic [NODE_CNT-1:0] rd_deps;
    logic [NODE_W-1:0]   rd_dst;
    logic [FLIT_W-1:0]   rd_flits;
    logic                overflow;

    rule_recorder #(.DEPTH(DEPTH), .INTERVAL(INTERVAL)) uut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_src(rx_src),
        .tx_valid(tx_valid), .tx_dst(tx_dst), .tx_flits(tx_flits),
        .rd_en(rd_en), .rd_idx(rd_idx), .rd_valid(rd_valid),
        .rd_used(rd_used), .rd_hits(rd_hits), .rd_deps(rd_deps),
        .rd_dst(rd_dst), .rd_flits(rd_flits), .overflow(overflow)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // reference model built from the requirements
    rule_t   mtab [DEPTH];
    int      mfill = 0;
    bit      movf  = 1'b0;
    depvec_t mvec  = '0;
    int      cyc   = 0;

    typedef struct {
        rule_t exp;
        int    idx;
        string tag;
    } rd_item_t;
    rd_item_t expq [$];

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_edge(input bit rv, input logic [NODE_W-1:0] rs, input bit tv,
                              input logic [NODE_W-1:0] td, input logic [FLIT_W-1:0] tf);
        depvec_t   cur;
        rule_key_t k;
        bit        found;
        bit        wend;
        cyc++;
        wend = (cyc % INTERVAL) == 0;
        cur  = mvec;
        if (rv) cur[rs] = 1'b1;
        if (tv) begin
            k = '{deps: cur, dst: td, flits: tf};
            found = 1'b0;
            for (int i = 0; i < mfill; i++) begin
                if (!found && mtab[i].key == k) begin
                    found = 1'b1;
                    if (mtab[i].hits != 2'd3) mtab[i].hits = mtab[i].hits + 1'b1;
                end
            end
            if (!found) begin
                if (mfill < DEPTH) begin
                    mtab[mfill] = '{valid: 1'b1, hits: '0, key: k};
                    mfill++;
                end else begin
                    movf = 1'b1;
                end
            end
        end
        mvec = (tv || wend) ? '0 : cur;
    endtask

    task automatic tick(input bit rv, input logic [NODE_W-1:0] rs, input bit tv,
                        input logic [NODE_W-1:0] td, input logic [FLIT_W-1:0] tf,
                        input bit re, input int ri, input string tag);
        @(negedge clk);
        rx_valid = rv; rx_src = rs; tx_valid = tv; tx_dst = td; tx_flits = tf;
        rd_en = re; rd_idx = IDX_W'(ri);
        if (re) expq.push_back('{exp: mtab[ri], idx: ri, tag: tag});
        @(posedge clk);
        model_edge(rv, rs, tv, td, tf);
    endtask

    task automatic idle();
        tick(0, 0, 0, 0, 0, 0, 0, "");
    endtask

    task automatic rd(input int ri, input string tag);
        tick(0, 0, 0, 0, 0, 1, ri, tag);
    endtask

    task automatic to_window_last();
        while (((cyc + 1) % INTERVAL) != 0) idle();
    endtask

    // monitor: pops expected read results as they appear
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (expq.size() == 0) begin
                check(1'b0, "R8", "unexpected rd_valid", 1, 0);
            end else begin
                rd_item_t it;
                it = expq.pop_front();
                check({rd_used, rd_hits, rd_deps, rd_dst, rd_flits} == it.exp, it.tag,
                      $sformatf("slot %0d", it.idx),
                      64'({rd_used, rd_hits, rd_deps, rd_dst, rd_flits}), 64'(it.exp));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            check(1'b0, "R9", "watchdog expired", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) mtab[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(overflow == 1'b0, "R9", "overflow after reset", 64'(overflow), 0);
        check(rd_valid == 1'b0, "R9", "rd_valid after reset", 64'(rd_valid), 0);
        @(posedge clk);
        model_edge(0, 0, 0, 0, 0);

        // R9: empty table reads as zeros
        rd(0, "R9");
        rd(DEPTH - 1, "R9");

        // R1 R2: arrivals from 1 and 2, then a send
        tick(1, 1, 0, 0, 0, 0, 0, "");
        tick(1, 2, 0, 0, 0, 0, 0, "");
        tick(0, 0, 1, 3, 4, 0, 0, "");
        rd(0, "R2");
        rd(1, "R2");

        // R3: repeat the same pattern, merge and saturate
        for (int n = 0; n < 4; n++) begin
            to_window_last();
            idle();
            tick(1, 2, 0, 0, 0, 0, 0, "");
            tick(1, 1, 0, 0, 0, 0, 0, "");
            tick(0, 0, 1, 3, 4, 0, 0, "");
            rd(0, "R3");
            rd(1, "R3");
        end

        // R6: arrival and send in the same cycle
        tick(1, 5, 1, 7, 2, 0, 0, "");
        // R4: immediately following send sees a cleared vector
        tick(0, 0, 1, 8, 1, 0, 0, "");
        rd(1, "R6");
        rd(2, "R4");

        // R5: arrival in the last window cycle is gone for a later send
        to_window_last();
        tick(1, 9, 0, 0, 0, 0, 0, "");
        tick(0, 0, 1, 1, 9, 0, 0, "");
        rd(3, "R5");
        // R5: same arrival with a send in that last cycle still counts
        to_window_last();
        tick(1, 9, 1, 2, 9, 0, 0, "");
        rd(4, "R5");
        // R1: arrivals accumulate across cycles within a window
        to_window_last();
        idle();
        tick(1, 0, 0, 0, 0, 0, 0, "");
        tick(1, 15, 0, 0, 0, 0, 0, "");
        tick(1, 15, 1, 4, 3, 0, 0, "");
        rd(5, "R1");

        // R7: fill the table and overflow it
        for (int i = 0; i < DEPTH; i++) begin
            tick(0, 0, 1, NODE_W'(i % NODE_CNT), FLIT_W'(100 + i), 0, 0, "");
        end
        idle();
        check(overflow == movf, "R7", "overflow after fill", 64'(overflow), 64'(movf));
        // a stored key still merges when full
        tick(0, 0, 1, 0, 100, 0, 0, "");
        tick(1, 3, 1, 5, 200, 0, 0, "");
        idle();
        check(overflow == 1'b1, "R7", "overflow sticky", 64'(overflow), 1);

        // R8: read back every slot
        for (int i = 0; i < DEPTH; i++) rd(i, "R8");
        idle();
        idle();
        check(rd_valid == 1'b0, "R8", "rd_valid low without request", 64'(rd_valid), 0);
        check(expq.size() == 0, "R8", "reads outstanding", 64'(expq.size()), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule